// File: doc/BRIEF.md
# Block Address Translation Matcher

This block translates a 32-bit effective address through a small set of programmable block-mapping entries. It keeps two independent arrays of entries, one consulted for instruction fetches and one for data reads and writes. Each entry is a pair of 32-bit registers. The upper register names an effective-address block and says for which privilege levels the entry is usable. The lower register gives the physical block base and a two-bit protection code.

Each block has a variable size. A block-length field masks effective-address bits 27:17 out of the comparison, and those same bits pass straight into the physical address. The array is scanned from entry 0 upward. The first entry that both matches and is usable at the current privilege level supplies the translation. The result gives the physical address, the read/write/execute permission and a flag that says whether the requested kind of access is allowed. It is registered and appears one cycle after the request.

Software loads the registers through a single write port. A write selects the array, the entry index and the upper or lower register.

Top module: `blkmap_xlate`

## Requirements
- R1: A request with `req_kind` = 2 (fetch) searches the instruction array. Kinds 0 (read), 1 (write) and 3 (treated as read) search the data array.
- R2: Among entries that both match and are usable, the lowest-numbered one supplies the result. An entry that matches but is not usable at the request's privilege is skipped, and the search continues.
- R3: Let BL = upper[12:2]. An entry matches when ea[31:28] == upper[31:28] and (ea[27:17] & ~BL) == upper[27:17].
- R4: An entry is usable for a supervisor request (`req_user` = 0) when upper[1] is set. It is usable for a user request (`req_user` = 1) when upper[0] is set.
- R5: The protection code lower[1:0] decodes into `rsp_perm` = {exec, write, read}. Code 0 gives 3'b000, code 2 gives 3'b111, and codes 1 and 3 give 3'b101.
- R6: On a hit, `rsp_pa` = {lower[31:28], (ea[27:17] & BL) | lower[27:17], ea[16:0]}.
- R7: On a hit, `rsp_ok` is the execute bit for a fetch, the write bit for a write and the read bit for a read.
- R8: When no entry both matches and is usable, `rsp_hit`, `rsp_pa`, `rsp_perm` and `rsp_ok` are all zero.
- R9: The result for a request appears on the clock edge that follows it, with `rsp_valid` = 1. A cycle without `req_valid` produces `rsp_valid` = 0 and all result outputs zero.
- R10: Reset clears every entry register and every output. After reset, every request misses.
- R11: When `cfg_we` = 1, `cfg_data` is written into the register chosen by `cfg_iside` (1 = instruction, 0 = data), `cfg_idx` and `cfg_upper` (1 = upper, 0 = lower). A request in the same cycle still sees the old contents. The new contents take effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_iside | input | 1 | 1 = instruction array, 0 = data array |
| cfg_idx | input | 2 | Entry index to write |
| cfg_upper | input | 1 | 1 = upper register, 0 = lower register |
| cfg_data | input | 32 | Register write data |
| req_valid | input | 1 | Request present this cycle |
| req_ea | input | 32 | Effective address |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 read |
| req_user | input | 1 | 1 = user privilege, 0 = supervisor |
| rsp_valid | output | 1 | Result present |
| rsp_hit | output | 1 | A usable entry matched |
| rsp_pa | output | 32 | Physical address |
| rsp_perm | output | 3 | {exec, write, read} permission |
| rsp_ok | output | 1 | Requested access is permitted |

## Verification
The assertions assume that a request's effective address and kind are stable around the clock edge that registers them. The offset and fetch-permission checks compare the response with those inputs one cycle earlier. The bench meets this by changing every input only on the falling clock edge.

The assertions also assume that a programmed entry keeps its stored block bits clear wherever its block-length mask is set. Such an entry could otherwise never match, and the hit-related properties would go untested. Every entry the bench loads follows this rule. Configuration writes are allowed to coincide with requests, and the bench does this on purpose to exercise the ordering in R11.

// File: rtl/blkmap_pkg.sv
// Shared types for the block address translation matcher.
// Assumes 32-bit effective and physical addresses with fixed field positions.
package blkmap_pkg;

    localparam int ADDR_W = 32;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    typedef struct packed {
        logic x;
        logic w;
        logic r;
    } perm_t;

    // Turn a two-bit protection code into read/write/execute rights.
    function automatic perm_t decode_prot(input logic [1:0] code);
        perm_t p;
        case (code)
            2'd0:    p = '{x: 1'b0, w: 1'b0, r: 1'b0};
            2'd2:    p = '{x: 1'b1, w: 1'b1, r: 1'b1};
            default: p = '{x: 1'b1, w: 1'b0, r: 1'b1};
        endcase
        return p;
    endfunction

endpackage

// File: rtl/blkmap_regs.sv
// Register store holding upper/lower pairs for the instruction and data arrays.
// Assumes a single write port; the write lands on the clock edge, so readers
// see the old value in the cycle of the write.
module blkmap_regs
    import blkmap_pkg::*;
#(
    parameter int NUM_ENT = 4,
    localparam int IDX_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we,
    input  logic                           iside,
    input  logic [IDX_W-1:0]               idx,
    input  logic                           upper_sel,
    input  logic [ADDR_W-1:0]              wdata,
    output logic [NUM_ENT-1:0][ADDR_W-1:0] i_up,
    output logic [NUM_ENT-1:0][ADDR_W-1:0] i_lo,
    output logic [NUM_ENT-1:0][ADDR_W-1:0] d_up,
    output logic [NUM_ENT-1:0][ADDR_W-1:0] d_lo
);

    // Clear every entry on reset; otherwise write the selected register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            i_up <= '0;
            i_lo <= '0;
            d_up <= '0;
            d_lo <= '0;
        end else if (we) begin
            case ({iside, upper_sel})
                2'b11:   i_up[idx] <= wdata;
                2'b10:   i_lo[idx] <= wdata;
                2'b01:   d_up[idx] <= wdata;
                default: d_lo[idx] <= wdata;
            endcase
        end
    end

endmodule

// File: rtl/blkmap_entry.sv
// Compare logic for one entry: block match, privilege usability,
// physical address formation and protection decode.
// Assumes the stored block bits are clear wherever the length mask is set.
module blkmap_entry
    import blkmap_pkg::*;
(
    input  logic [ADDR_W-1:0] upper,
    input  logic [ADDR_W-1:0] lower,
    input  logic [ADDR_W-1:0] ea,
    input  logic              user,
    output logic              usable_hit,
    output logic [ADDR_W-1:0] pa,
    output perm_t             perm
);

    logic [10:0] len_mask;
    logic        tag_eq;
    logic        priv_ok;

    // Block-length field selects the low block bits that are ignored.
    assign len_mask = upper[12:2];

    // Match the fixed high nibble and the unmasked low block bits.
    always_comb begin
        tag_eq  = (ea[31:28] == upper[31:28]) &&
                  ((ea[27:17] & ~len_mask) == upper[27:17]);
        priv_ok = user ? upper[0] : upper[1];
        usable_hit = tag_eq && priv_ok;
    end

    // Physical address mixes stored base and passed-through address bits.
    always_comb begin
        pa   = {lower[31:28], (ea[27:17] & len_mask) | lower[27:17], ea[16:0]};
        perm = decode_prot(lower[1:0]);
    end

endmodule

// File: rtl/blkmap_pick.sv
// Priority selector: the lowest-indexed usable hit supplies the result.
// Assumes nothing about how many entries hit at once.
module blkmap_pick
    import blkmap_pkg::*;
#(
    parameter int NUM_ENT = 4
) (
    input  logic [NUM_ENT-1:0]             hits,
    input  logic [NUM_ENT-1:0][ADDR_W-1:0] pa_in,
    input  perm_t [NUM_ENT-1:0]            perm_in,
    output logic                           found,
    output logic [NUM_ENT-1:0]             grant,
    output logic [ADDR_W-1:0]              pa,
    output perm_t                          perm
);

    // Scan upward and keep the first usable hit.
    always_comb begin
        found = 1'b0;
        grant = '0;
        pa    = '0;
        perm  = '0;
        for (int i = 0; i < NUM_ENT; i++) begin
            if (hits[i] && !found) begin
                found    = 1'b1;
                grant[i] = 1'b1;
                pa       = pa_in[i];
                perm     = perm_in[i];
            end
        end
    end

endmodule

// File: rtl/blkmap_xlate.sv
// Top of the block address translation matcher. Picks the instruction or
// data array by access kind, compares all entries in parallel, selects the
// lowest usable hit, checks the requested right and registers the result.
// Assumes request inputs are stable around the sampling clock edge.
module blkmap_xlate
    import blkmap_pkg::*;
#(
    parameter int NUM_ENT = 4,
    localparam int IDX_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_iside,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic             cfg_upper,
    input  logic [31:0]      cfg_data,
    input  logic             req_valid,
    input  logic [31:0]      req_ea,
    input  logic [1:0]       req_kind,
    input  logic             req_user,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic [31:0]      rsp_pa,
    output logic [2:0]       rsp_perm,
    output logic             rsp_ok
);

    logic [NUM_ENT-1:0][ADDR_W-1:0] i_up, i_lo, d_up, d_lo;
    logic [NUM_ENT-1:0][ADDR_W-1:0] sel_up, sel_lo, ent_pa;
    perm_t [NUM_ENT-1:0]            ent_perm;
    logic [NUM_ENT-1:0]             ent_hit, grant;
    logic                           found;
    logic [ADDR_W-1:0]              win_pa;
    perm_t                          win_perm;
    logic                           right_ok;

    blkmap_regs #(.NUM_ENT(NUM_ENT)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (cfg_we),
        .iside     (cfg_iside),
        .idx       (cfg_idx),
        .upper_sel (cfg_upper),
        .wdata     (cfg_data),
        .i_up      (i_up),
        .i_lo      (i_lo),
        .d_up      (d_up),
        .d_lo      (d_lo)
    );

    // Fetches consult the instruction array, everything else the data array.
    always_comb begin
        if (acc_kind_e'(req_kind) == ACC_FETCH) begin
            sel_up = i_up;
            sel_lo = i_lo;
        end else begin
            sel_up = d_up;
            sel_lo = d_lo;
        end
    end

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
        blkmap_entry u_ent (
            .upper      (sel_up[g]),
            .lower      (sel_lo[g]),
            .ea         (req_ea),
            .user       (req_user),
            .usable_hit (ent_hit[g]),
            .pa         (ent_pa[g]),
            .perm       (ent_perm[g])
        );
    end

    blkmap_pick #(.NUM_ENT(NUM_ENT)) u_pick (
        .hits    (ent_hit),
        .pa_in   (ent_pa),
        .perm_in (ent_perm),
        .found   (found),
        .grant   (grant),
        .pa      (win_pa),
        .perm    (win_perm)
    );

    // Check the right that the requested access kind needs.
    always_comb begin
        case (acc_kind_e'(req_kind))
            ACC_FETCH: right_ok = win_perm.x;
            ACC_WRITE: right_ok = win_perm.w;
            default:   right_ok = win_perm.r;
        endcase
    end

    // Register the result; misses and idle cycles leave every field at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_pa    <= '0;
            rsp_perm  <= '0;
            rsp_ok    <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            rsp_hit   <= req_valid && found;
            rsp_pa    <= (req_valid && found) ? win_pa : '0;
            rsp_perm  <= (req_valid && found) ? win_perm : 3'b000;
            rsp_ok    <= req_valid && found && right_ok;
        end
    end

    assert_single_winner_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && (found == (grant != '0)));

    assert_write_implies_rx_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_perm[1] |-> (rsp_perm[0] && rsp_perm[2]));

    assert_low_bits_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> (rsp_pa[16:0] == $past(req_ea[16:0])));

    assert_fetch_needs_exec_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_ok && ($past(req_kind) == 2'd2)) |-> rsp_perm[2]);

    assert_ok_needs_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ok |-> (rsp_hit && rsp_valid));

    assert_miss_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!rsp_hit) |-> (rsp_pa == '0 && rsp_perm == '0 && !rsp_ok));

    assert_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_hit));

endmodule

// File: tb/test_blkmap_xlate.sv
`timescale 1ns/1ps
module test_blkmap_xlate;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we, cfg_iside, cfg_upper;
    logic [1:0]  cfg_idx;
    logic [31:0] cfg_data;
    logic        req_valid, req_user;
    logic [31:0] req_ea;
    logic [1:0]  req_kind;
    logic        rsp_valid, rsp_hit, rsp_ok;
    logic [31:0] rsp_pa;
    logic [2:0]  rsp_perm;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    always #2.5 clk = ~clk;

    blkmap_xlate i_blkmap_xlate (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_iside(cfg_iside), .cfg_idx(cfg_idx),
        .cfg_upper(cfg_upper), .cfg_data(cfg_data),
        .req_valid(req_valid), .req_ea(req_ea), .req_kind(req_kind),
        .req_user(req_user),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_pa(rsp_pa),
        .rsp_perm(rsp_perm), .rsp_ok(rsp_ok)
    );

    // Fields: ea[71:40] kind[39:38] user[37] hit[36] pa[35:4] perm[3:1] ok[0]
    localparam int NVEC = 14;
    localparam logic [71:0] VEC [NVEC] = '{
        {32'h1000_1234, 2'd0, 1'b0, 1'b1, 32'h8000_1234, 3'b111, 1'b1}, // R3 R4 R6 entry 0 sup
        {32'h1001_F678, 2'd1, 1'b0, 1'b1, 32'h8001_F678, 3'b111, 1'b1}, // R6 R7 write
        {32'h1000_0ABC, 2'd1, 1'b1, 1'b1, 32'h9000_0ABC, 3'b101, 1'b0}, // R2 R4 skip, R7 denied
        {32'h1000_0ABC, 2'd0, 1'b1, 1'b1, 32'h9000_0ABC, 3'b101, 1'b1}, // R5 code 1
        {32'h1000_0ABC, 2'd2, 1'b1, 1'b1, 32'h7000_0ABC, 3'b111, 1'b1}, // R1 fetch side
        {32'h2015_4321, 2'd0, 1'b0, 1'b1, 32'h4015_4321, 3'b101, 1'b1}, // R3 R6 masked bits
        {32'h2015_4321, 2'd1, 1'b0, 1'b1, 32'h4015_4321, 3'b101, 1'b0}, // R5 code 3, R7
        {32'h2020_0000, 2'd0, 1'b0, 1'b0, 32'h0000_0000, 3'b000, 1'b0}, // R3 outside block, R8
        {32'h3000_0010, 2'd0, 1'b0, 1'b1, 32'h5000_0010, 3'b000, 1'b0}, // R5 code 0
        {32'h3000_0010, 2'd2, 1'b0, 1'b0, 32'h0000_0000, 3'b000, 1'b0}, // R1 R8 fetch miss
        {32'h0000_0FFF, 2'd2, 1'b1, 1'b1, 32'h6000_0FFF, 3'b101, 1'b1}, // R1 R7 exec
        {32'h1000_1234, 2'd3, 1'b0, 1'b1, 32'h8000_1234, 3'b111, 1'b1}, // R1 R7 kind 3 as read
        {32'h1002_0000, 2'd0, 1'b0, 1'b0, 32'h0000_0000, 3'b000, 1'b0}, // R3 unmasked bit set
        {32'h0000_0FFF, 2'd1, 1'b0, 1'b0, 32'h0000_0000, 3'b000, 1'b0}  // R1 data side miss
    };

    task automatic check(input string tag, input logic [37:0] got, input logic [37:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic cfg_write(input logic iside, input logic [1:0] idx,
                             input logic upper, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_iside = iside; cfg_idx = idx; cfg_upper = upper; cfg_data = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic request(input logic [31:0] ea, input logic [1:0] kind, input logic user);
        req_valid = 1'b1; req_ea = ea; req_kind = kind; req_user = user;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    function automatic logic [37:0] rsp_now();
        return {rsp_valid, rsp_hit, rsp_pa, rsp_perm, rsp_ok};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL R9 watchdog: actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_iside = 1'b0; cfg_idx = '0; cfg_upper = 1'b0;
        cfg_data = '0; req_valid = 1'b0; req_ea = '0; req_kind = '0; req_user = 1'b0;
        repeat (3) @(negedge clk);
        check("R10 reset outputs", rsp_now(), 38'h0);
        rst_n = 1'b1;

        // Data array
        cfg_write(1'b0, 2'd0, 1'b1, 32'h1000_0002); cfg_write(1'b0, 2'd0, 1'b0, 32'h8000_0002);
        cfg_write(1'b0, 2'd1, 1'b1, 32'h1000_0001); cfg_write(1'b0, 2'd1, 1'b0, 32'h9000_0001);
        cfg_write(1'b0, 2'd2, 1'b1, 32'h2000_003F); cfg_write(1'b0, 2'd2, 1'b0, 32'h4000_0003);
        cfg_write(1'b0, 2'd3, 1'b1, 32'h3000_0003); cfg_write(1'b0, 2'd3, 1'b0, 32'h5000_0000);
        // Instruction array (R11 selection of side)
        cfg_write(1'b1, 2'd0, 1'b1, 32'h1000_0003); cfg_write(1'b1, 2'd0, 1'b0, 32'h7000_0002);
        cfg_write(1'b1, 2'd1, 1'b1, 32'h0000_0003); cfg_write(1'b1, 2'd1, 1'b0, 32'h6000_0001);

        @(negedge clk);
        for (int i = 0; i < NVEC; i++) begin
            request(VEC[i][71:40], VEC[i][39:38], VEC[i][37]);
            check($sformatf("vec%0d R1/R2/R3/R4/R5/R6/R7/R8", i), rsp_now(),
                  {1'b1, VEC[i][36:0]});
        end

        // R9: idle cycle gives no response
        @(negedge clk);
        check("R9 idle", rsp_now(), 38'h0);

        // R2: a later overlapping entry does not displace entry 0
        cfg_write(1'b1, 2'd2, 1'b1, 32'h1000_0003);
        cfg_write(1'b1, 2'd2, 1'b0, 32'h2000_0001);
        request(32'h1000_0ABC, 2'd2, 1'b0);
        check("R2 priority", rsp_now(), {1'b1, 1'b1, 32'h7000_0ABC, 3'b111, 1'b1});

        // R11: write in the same cycle as a request; old contents used
        cfg_we = 1'b1; cfg_iside = 1'b1; cfg_idx = 2'd0; cfg_upper = 1'b1; cfg_data = 32'h0;
        request(32'h1000_0ABC, 2'd2, 1'b0);
        cfg_we = 1'b0;
        check("R11 same-cycle old", rsp_now(), {1'b1, 1'b1, 32'h7000_0ABC, 3'b111, 1'b1});
        request(32'h1000_0ABC, 2'd2, 1'b0);
        check("R11 new contents, R2 fallthrough", rsp_now(),
              {1'b1, 1'b1, 32'h2000_0ABC, 3'b101, 1'b1});
        // R11: data side untouched by instruction write
        request(32'h1000_1234, 2'd0, 1'b0);
        check("R11 other side kept", rsp_now(), {1'b1, 1'b1, 32'h8000_1234, 3'b111, 1'b1});

        // R10: reset clears entries
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        request(32'h1000_1234, 2'd0, 1'b0);
        check("R10 entries cleared", rsp_now(), {1'b1, 37'h0});

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule